// File: doc/BRIEF.md
# Incremental encoder position counter

This block turns the signals of an incremental motion encoder into a position. A phase counter tracks steps within one revolution and runs from 0 to a programmable limit. A revolution counter tracks whole turns. A direction flag records the sense of the most recent step. The A, B, Z and home inputs are already synchronised to `clk`. The block samples them on every rising edge and compares each sample with the one before it.

Three input formats are supported. In the first, A and B are two square waves a quarter cycle apart, and all four edges of each cycle are counted. In the second, A is a step pulse and B gives the direction. In the third, A carries up pulses and B carries down pulses. The revolution counter has two modes: it can count rising edges of Z, or it can count wraps of the phase counter. A Z edge can also recalibrate the phase counter to a programmed index. The home input clears whichever counters its mask selects. A software clear holds both counters at zero.

All ports are plain control and status signals sampled every cycle. There is no valid/ready stream, so there is no back-pressure: each input sample is used in the cycle it arrives, and each output reflects the state after the most recent clock edge.

Top module: `qenc_pos_counter`

## Requirements
- R1: After reset, `ph_count`, `z_count`, `dir`, `a_level` and `b_level` are all 0.
- R2: With `cfg_mode` = 0, the pair {A,B} moving one place forward in the order 00, 10, 11, 01, 00 is one up step, and moving one place back is one down step. A change of both bits at once, or no change, is no step.
- R3: With `cfg_mode` = 1, each rising edge of A is one step: up when B is 0, down when B is 1. With `cfg_mode` = 2, a rising edge of A alone is an up step, a rising edge of B alone is a down step, and both rising together is no step. With `cfg_mode` = 3, nothing counts.
- R4: An up step from a phase count at or above `cfg_ph_max` gives 0, and any other up step adds 1. A down step from 0 gives `cfg_ph_max`, and any other down step subtracts 1.
- R5: With `cfg_zmode` = 0, each rising edge of Z adds 1 to `z_count` if the direction after that cycle's step is up, and subtracts 1 if it is down. Z held high counts only once. The count wraps modulo 2^Z_W.
- R6: With `cfg_zmode` = 1, `z_count` adds 1 when the phase counter steps up from its limit to 0, and subtracts 1 when it steps down from 0 to its limit. Z edges do not change `z_count`.
- R7: With `cfg_zcal` = 1, a rising edge of Z loads `cfg_index` into the phase counter, and this load takes the place of any step in that cycle.
- R8: While `in_home` is 1, bit 0 of `cfg_home_mask` holds `z_count` at 0 and bit 1 holds `ph_count` at 0. Home takes precedence over calibration and steps.
- R9: While `sw_clr` is 1, both counters are held at 0, and edges seen during the clear are never counted afterwards. Counting resumes from 0 after release.
- R10: `dir` becomes 0 after an up step and 1 after a down step, and it keeps its value in cycles with no step.
- R11: `a_level` and `b_level` show the A and B inputs sampled at the last clock edge, and every counter result appears one clock edge after the input sample that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_clr | input | 1 | Software clear; holds both counters at 0 while high |
| in_a | input | 1 | Encoder A (quadrature A, step pulse, or up pulse) |
| in_b | input | 1 | Encoder B (quadrature B, direction, or down pulse) |
| in_z | input | 1 | Index pulse, active on its rising edge |
| in_home | input | 1 | Home input, level sensitive |
| cfg_mode | input | 2 | Input format: 0 quadrature, 1 step/direction, 2 up/down, 3 off |
| cfg_ph_max | input | PH_W | Phase limit (number of counts minus one) |
| cfg_index | input | PH_W | Phase value loaded on a calibrating Z edge |
| cfg_zmode | input | 1 | Revolution counter source: 0 Z edges, 1 phase wraps |
| cfg_zcal | input | 1 | Enables phase calibration on Z |
| cfg_home_mask | input | 2 | Bit 0 lets home clear the revolution count; bit 1 lets it clear the phase count |
| ph_count | output | PH_W | Phase count |
| z_count | output | Z_W | Revolution count |
| dir | output | 1 | Direction of the last step, 1 meaning down |
| a_level | output | 1 | Sampled A level |
| b_level | output | 1 | Sampled B level |

## Verification
The bench builds the block with PH_W = 8 and Z_W = 4. The narrow revolution counter lets a single down count from zero show the modulo wrap. The phase limit is set to values from 0 to 12, so up wraps, down wraps and the single-value case where the limit is 0 all occur often. Random runs also leave the calibration index above the limit from time to time, which exercises the rule that an up step from at or above the limit returns to 0.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

  typedef enum logic [1:0] {
    FMT_QUAD      = 2'd0,
    FMT_STEP_DIR  = 2'd1,
    FMT_UP_DOWN   = 2'd2,
    FMT_IDLE      = 2'd3
  } qenc_fmt_e;

  // Position of an {A,B} pair along the forward quadrature order.
  function automatic logic [1:0] quad_pos(input logic a, input logic b);
    case ({a, b})
      2'b00:   return 2'd0;
      2'b10:   return 2'd1;
      2'b11:   return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/qenc_input_stage.sv
module qenc_input_stage #(
  parameter int N_SIG = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SIG-1:0] sig_now,
  output logic [N_SIG-1:0] sig_prev,
  output logic [N_SIG-1:0] sig_rise
);

  for (genvar g = 0; g < N_SIG; g++) begin : g_sig
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sig_prev[g] <= 1'b0;
      else        sig_prev[g] <= sig_now[g];
    end
    assign sig_rise[g] = sig_now[g] & ~sig_prev[g];
  end

endmodule

// File: rtl/qenc_step_decode.sv
module qenc_step_decode
  import qenc_pkg::*;
(
  input  qenc_fmt_e fmt,
  input  logic      a_prev,
  input  logic      b_prev,
  input  logic      a_now,
  input  logic      b_now,
  output logic      step_up,
  output logic      step_dn
);

  logic [1:0] delta;
  logic       a_rise;
  logic       b_rise;

  assign delta  = quad_pos(a_now, b_now) - quad_pos(a_prev, b_prev);
  assign a_rise = a_now & ~a_prev;
  assign b_rise = b_now & ~b_prev;

  always_comb begin
    step_up = 1'b0;
    step_dn = 1'b0;
    unique case (fmt)
      FMT_QUAD: begin
        step_up = (delta == 2'd1);
        step_dn = (delta == 2'd3);
      end
      FMT_STEP_DIR: begin
        step_up = a_rise & ~b_now;
        step_dn = a_rise &  b_now;
      end
      FMT_UP_DOWN: begin
        step_up = a_rise & ~b_rise;
        step_dn = b_rise & ~a_rise;
      end
      default: begin
        step_up = 1'b0;
        step_dn = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/qenc_phase_counter.sv
module qenc_phase_counter #(
  parameter int PH_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hold_zero,
  input  logic            load_idx,
  input  logic [PH_W-1:0] idx_val,
  input  logic [PH_W-1:0] max_val,
  input  logic            step_up,
  input  logic            step_dn,
  output logic [PH_W-1:0] ph_q,
  output logic            wrap_up,
  output logic            wrap_dn
);

  logic            at_max;
  logic            at_zero;
  logic            take_step;
  logic [PH_W-1:0] ph_d;

  assign at_max    = (ph_q >= max_val);
  assign at_zero   = (ph_q == '0);
  assign take_step = ~hold_zero & ~load_idx;
  assign wrap_up   = take_step & step_up & at_max;
  assign wrap_dn   = take_step & step_dn & at_zero;

  always_comb begin
    ph_d = ph_q;
    if (hold_zero)     ph_d = '0;
    else if (load_idx) ph_d = idx_val;
    else if (step_up)  ph_d = at_max  ? '0      : ph_q + 1'b1;
    else if (step_dn)  ph_d = at_zero ? max_val : ph_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  p_hold_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hold_zero |=> (ph_q == '0));

  p_load_idx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_idx && !hold_zero) |=> (ph_q == $past(idx_val)));

  p_wrap_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take_step && step_up && ph_q >= max_val) |=> (ph_q == '0));

  p_wrap_dn_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take_step && step_dn && ph_q == '0) |=> (ph_q == $past(max_val)));

endmodule

// File: rtl/qenc_rev_counter.sv
module qenc_rev_counter #(
  parameter int Z_W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hold_zero,
  input  logic           inc,
  input  logic           dec,
  output logic [Z_W-1:0] z_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         z_q <= '0;
    else if (hold_zero) z_q <= '0;
    else if (inc)       z_q <= z_q + 1'b1;
    else if (dec)       z_q <= z_q - 1'b1;
  end

  p_inc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !hold_zero) |=> (z_q == Z_W'($past(z_q) + 1'b1)));

  p_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !inc && !hold_zero) |=> (z_q == Z_W'($past(z_q) - 1'b1)));

  p_home_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_zero |=> (z_q == '0));

endmodule

// File: rtl/qenc_pos_counter.sv
module qenc_pos_counter
  import qenc_pkg::*;
#(
  parameter int PH_W = 16,
  parameter int Z_W  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sw_clr,
  input  logic            in_a,
  input  logic            in_b,
  input  logic            in_z,
  input  logic            in_home,
  input  logic [1:0]      cfg_mode,
  input  logic [PH_W-1:0] cfg_ph_max,
  input  logic [PH_W-1:0] cfg_index,
  input  logic            cfg_zmode,
  input  logic            cfg_zcal,
  input  logic [1:0]      cfg_home_mask,
  output logic [PH_W-1:0] ph_count,
  output logic [Z_W-1:0]  z_count,
  output logic            dir,
  output logic            a_level,
  output logic            b_level
);

  localparam int N_SIG = 3;
  localparam int IX_A  = 0;
  localparam int IX_B  = 1;
  localparam int IX_Z  = 2;

  logic [N_SIG-1:0] sig_now;
  logic [N_SIG-1:0] sig_prev;
  logic [N_SIG-1:0] sig_rise;
  logic             step_up;
  logic             step_dn;
  logic             dir_q;
  logic             dir_next;
  logic             z_edge;
  logic             ph_hold;
  logic             ph_load;
  logic             z_hold;
  logic             wrap_up;
  logic             wrap_dn;
  logic             rev_inc;
  logic             rev_dec;

  assign sig_now = {in_z, in_b, in_a};

  qenc_input_stage #(.N_SIG(N_SIG)) u_inp (
    .clk      (clk),
    .rst_n    (rst_n),
    .sig_now  (sig_now),
    .sig_prev (sig_prev),
    .sig_rise (sig_rise)
  );

  qenc_step_decode u_dec (
    .fmt     (qenc_fmt_e'(cfg_mode)),
    .a_prev  (sig_prev[IX_A]),
    .b_prev  (sig_prev[IX_B]),
    .a_now   (in_a),
    .b_now   (in_b),
    .step_up (step_up),
    .step_dn (step_dn)
  );

  assign dir_next = step_up ? 1'b0 : (step_dn ? 1'b1 : dir_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir_q <= 1'b0;
    else        dir_q <= dir_next;
  end

  assign z_edge  = sig_rise[IX_Z];
  assign ph_hold = sw_clr | (in_home & cfg_home_mask[1]);
  assign ph_load = z_edge & cfg_zcal;
  assign z_hold  = sw_clr | (in_home & cfg_home_mask[0]);

  qenc_phase_counter #(.PH_W(PH_W)) u_ph (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_zero (ph_hold),
    .load_idx  (ph_load),
    .idx_val   (cfg_index),
    .max_val   (cfg_ph_max),
    .step_up   (step_up),
    .step_dn   (step_dn),
    .ph_q      (ph_count),
    .wrap_up   (wrap_up),
    .wrap_dn   (wrap_dn)
  );

  always_comb begin
    if (cfg_zmode) begin
      rev_inc = wrap_up;
      rev_dec = wrap_dn;
    end else begin
      rev_inc = z_edge & ~dir_next;
      rev_dec = z_edge &  dir_next;
    end
  end

  qenc_rev_counter #(.Z_W(Z_W)) u_rev (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_zero (z_hold),
    .inc       (rev_inc),
    .dec       (rev_dec),
    .z_q       (z_count)
  );

  assign dir     = dir_q;
  assign a_level = sig_prev[IX_A];
  assign b_level = sig_prev[IX_B];

  p_single_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({step_up, step_dn}));

  p_dir_up_r10: assert property (@(posedge clk) disable iff (!rst_n)
    step_up |=> !dir);

  p_dir_dn_r10: assert property (@(posedge clk) disable iff (!rst_n)
    step_dn |=> dir);

  p_dir_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_up && !step_dn) |=> $stable(dir));

  p_z_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_zmode && !z_hold && !(in_z && !a_level_z_prev())) |=> $stable(z_count));

  function automatic logic a_level_z_prev();
    return sig_prev[IX_Z];
  endfunction

  p_no_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'd3) |-> (!step_up && !step_dn));

endmodule

// File: tb/qenc_pos_counter_tb.sv
module qenc_pos_counter_tb;

  localparam int CLK_PERIOD = 10;
  localparam int PH_W = 8;
  localparam int Z_W  = 4;
  localparam int Z_MOD = 1 << Z_W;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            sw_clr = 1'b0;
  logic            in_a = 1'b0, in_b = 1'b0, in_z = 1'b0, in_home = 1'b0;
  logic [1:0]      cfg_mode = 2'd0;
  logic [PH_W-1:0] cfg_ph_max = '0;
  logic [PH_W-1:0] cfg_index = '0;
  logic            cfg_zmode = 1'b0, cfg_zcal = 1'b0;
  logic [1:0]      cfg_home_mask = 2'b00;
  logic [PH_W-1:0] ph_count;
  logic [Z_W-1:0]  z_count;
  logic            dir, a_level, b_level;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;
  bit cmp_en = 0;
  int qidx = 0;

  // behavioural reference state
  int m_ph = 0, m_z = 0, m_dir = 0, m_a = 0, m_b = 0, m_zp = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qenc_pos_counter #(.PH_W(PH_W), .Z_W(Z_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .sw_clr(sw_clr), .in_a(in_a), .in_b(in_b),
    .in_z(in_z), .in_home(in_home), .cfg_mode(cfg_mode), .cfg_ph_max(cfg_ph_max),
    .cfg_index(cfg_index), .cfg_zmode(cfg_zmode), .cfg_zcal(cfg_zcal),
    .cfg_home_mask(cfg_home_mask), .ph_count(ph_count), .z_count(z_count),
    .dir(dir), .a_level(a_level), .b_level(b_level)
  );

  function automatic int qpos(input int a, input int b);
    if (a == 0 && b == 0) return 0;
    if (a == 1 && b == 0) return 1;
    if (a == 1 && b == 1) return 2;
    return 3;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_z = 0; m_dir = 0; m_a = 0; m_b = 0; m_zp = 0;
    end else begin
      int step, na, nb, nz, d, zr, wu, wd, mx;
      na = int'(in_a); nb = int'(in_b); nz = int'(in_z);
      mx = int'(cfg_ph_max);
      step = 0;
      if (cfg_mode == 2'd0) begin
        d = (qpos(na, nb) - qpos(m_a, m_b) + 4) % 4;
        if (d == 1) step = 1;
        if (d == 3) step = -1;
      end else if (cfg_mode == 2'd1) begin
        if (m_a == 0 && na == 1) step = (nb == 1) ? -1 : 1;
      end else if (cfg_mode == 2'd2) begin
        if (m_a == 0 && na == 1 && !(m_b == 0 && nb == 1)) step = 1;
        if (m_b == 0 && nb == 1 && !(m_a == 0 && na == 1)) step = -1;
      end
      if (step > 0) m_dir = 0;
      if (step < 0) m_dir = 1;
      zr = (nz == 1 && m_zp == 0) ? 1 : 0;
      wu = 0; wd = 0;
      if (sw_clr || (in_home && cfg_home_mask[1])) m_ph = 0;
      else if (zr == 1 && cfg_zcal) m_ph = int'(cfg_index);
      else if (step > 0) begin
        if (m_ph >= mx) begin m_ph = 0; wu = 1; end else m_ph = m_ph + 1;
      end else if (step < 0) begin
        if (m_ph == 0) begin m_ph = mx; wd = 1; end else m_ph = m_ph - 1;
      end
      if (sw_clr || (in_home && cfg_home_mask[0])) m_z = 0;
      else if (!cfg_zmode) begin
        if (zr == 1) m_z = (m_dir == 1) ? (m_z + Z_MOD - 1) % Z_MOD : (m_z + 1) % Z_MOD;
      end else begin
        if (wu == 1) m_z = (m_z + 1) % Z_MOD;
        if (wd == 1) m_z = (m_z + Z_MOD - 1) % Z_MOD;
      end
      m_a = na; m_b = nb; m_zp = nz;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // every-clock comparison against the reference model
  always @(negedge clk) begin
    if (cmp_en && rst_n && !done) begin
      check("R4 phase count", int'(ph_count), m_ph);
      check("R5 revolution count", int'(z_count), m_z);
      check("R10 direction", int'(dir), m_dir);
      check("R11 A level", int'(a_level), m_a);
      check("R11 B level", int'(b_level), m_b);
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic qmove(input int d);
    qidx = (qidx + d + 4) % 4;
    case (qidx)
      0: begin in_a = 0; in_b = 0; end
      1: begin in_a = 1; in_b = 0; end
      2: begin in_a = 1; in_b = 1; end
      default: begin in_a = 0; in_b = 1; end
    endcase
    tick();
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    tick(); tick(); tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    check("R1 phase", int'(ph_count), 0);
    check("R1 revolution", int'(z_count), 0);
    check("R1 dir", int'(dir), 0);
    check("R1 levels", int'({a_level, b_level}), 0);
    cmp_en = 1;

    // R2 / R4 / R6 quadrature with phase-wrap revolution counting
    cfg_mode = 2'd0; cfg_ph_max = 8'd9; cfg_zmode = 1'b1;
    tick();
    for (int i = 0; i < 12; i++) qmove(1);
    check("R2 up steps phase", int'(ph_count), 2);
    check("R6 up wrap revolution", int'(z_count), 1);
    check("R10 dir after up", int'(dir), 0);
    for (int i = 0; i < 5; i++) qmove(-1);
    check("R4 down wrap phase", int'(ph_count), 7);
    check("R6 down wrap revolution", int'(z_count), 0);
    check("R10 dir after down", int'(dir), 1);
    // invalid double transition: from 01 to 10
    in_a = 1; in_b = 0; qidx = 1;
    tick();
    check("R2 double change ignored", int'(ph_count), 7);

    // R5 Z-edge revolution counting, Z held high counts once, down direction
    cfg_zmode = 1'b0;
    tick();
    in_z = 1;
    tick(); tick(); tick();
    in_z = 0;
    tick();
    check("R5 single Z count down and wrap", int'(z_count), 15);

    // R7 calibration
    cfg_zcal = 1'b1; cfg_index = 8'd5;
    tick();
    in_z = 1; tick(); in_z = 0; tick();
    check("R7 index load", int'(ph_count), 5);
    check("R5 second Z", int'(z_count), 14);
    cfg_zcal = 1'b0;

    // R3 step/direction
    cfg_mode = 2'd1;
    tick();
    in_a = 0; tick();
    for (int i = 0; i < 3; i++) begin in_a = 1; tick(); in_a = 0; tick(); end
    check("R3 step/dir up", int'(ph_count), 8);
    in_b = 1; tick();
    in_a = 1; tick(); in_a = 0; tick();
    check("R3 step/dir down", int'(ph_count), 7);

    // R3 up/down format
    cfg_mode = 2'd2;
    in_b = 0; tick();
    in_a = 1; tick(); in_a = 0; tick();
    in_a = 1; tick(); in_a = 0; tick();
    in_b = 1; tick(); in_b = 0; tick();
    in_a = 1; in_b = 1; tick(); in_a = 0; in_b = 0; tick();
    check("R3 up/down net", int'(ph_count), 8);
    check("R10 dir after down pulse", int'(dir), 1);

    // R3 idle format
    cfg_mode = 2'd3;
    tick();
    for (int i = 0; i < 4; i++) begin in_a = ~in_a; tick(); in_b = ~in_b; tick(); end
    check("R3 idle format no count", int'(ph_count), 8);

    // R8 home with each mask bit
    cfg_home_mask = 2'b10; in_home = 1; tick(); in_home = 0; tick();
    check("R8 home clears phase", int'(ph_count), 0);
    check("R8 home keeps revolution", int'(z_count), 14);
    cfg_home_mask = 2'b01; in_home = 1; tick(); in_home = 0; tick();
    check("R8 home clears revolution", int'(z_count), 0);

    // R9 software clear
    cfg_mode = 2'd1; in_a = 0; in_b = 0; tick();
    in_a = 1; tick(); in_a = 0; tick();
    in_a = 1; tick(); in_a = 0; tick();
    check("R9 count before clear", int'(ph_count), 2);
    sw_clr = 1; tick();
    check("R9 clear holds zero", int'(ph_count), 0);
    in_a = 1; tick(); in_a = 0; tick(); in_a = 1; tick();
    check("R9 edges ignored while clear", int'(ph_count), 0);
    sw_clr = 0; tick();
    check("R9 no late count on release", int'(ph_count), 0);
    in_a = 0; tick(); in_a = 1; tick();
    check("R9 resumes from zero", int'(ph_count), 1);

    // R11 level sampling
    in_a = 0; in_b = 1; tick();
    check("R11 sampled A", int'(a_level), 0);
    check("R11 sampled B", int'(b_level), 1);

    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      if (i % 50 == 0) begin
        cfg_mode      = 2'($urandom % 4);
        cfg_ph_max    = 8'($urandom % 13);
        cfg_index     = 8'($urandom % 15);
        cfg_zmode     = 1'($urandom % 2);
        cfg_zcal      = 1'($urandom % 2);
        cfg_home_mask = 2'($urandom % 4);
      end
      in_a    = 1'($urandom % 2);
      in_b    = 1'($urandom % 2);
      if ($urandom % 6 == 0) in_z = ~in_z;
      in_home = ($urandom % 25 == 0);
      sw_clr  = ($urandom % 60 == 0);
      tick();
    end
    tick();
    finish_run();
  end

endmodule